// File: doc/BRIEF.md
# Sample Record Logger for a Serial No-Wait Memory

This block sits between a multi-channel sampling source and a byte-exchange serial memory port. Each sample strobe carries a record of several signed 16-bit channels. The block stores that record and turns it into one write frame towards a 32 KB serial memory that needs no write-cycle wait. The frame holds a write-enable opcode, a write opcode, a 16-bit start address and the record bytes, all under one chip-select low period. Each channel is sent low byte first, with channel 0 leading. Records are packed end to end, so the block keeps a count of stored records and a running byte address.

Once the next record can no longer fit, logging stops. A later upload request reads the whole logged region back in one sequential read frame from address zero. The bytes come out, in the order they were stored, on a valid/ready byte stream. A consumer can then rebuild each record's channels from groups of bytes. The serial shifter is outside this block: the block hands it one byte at a time and waits for the byte that comes back.

Serial port rules: `spi_tx` is offered with `spi_valid` and is taken on a cycle where `spi_ready` is high. Only one exchange is outstanding at a time. The byte shifted back arrives later as a one-cycle `spi_rx_valid` pulse. Upload stream rules: `up_data` and `up_last` are presented with `up_valid` and held unchanged until a cycle with `up_ready` high. The next memory byte is not fetched until the current one has been taken, so a stalled consumer simply pauses the read frame.

Top module: `rec_logger`

## Requirements
- R1: A sample strobe accepted while idle and not full produces one frame with chip select low throughout: 0x06, 0x02, address high byte, address low byte, then the record bytes. The address is the byte count before the record. Chip select returns high after the last byte.
- R2: Record bytes are ordered channel 0 first, and each channel is sent low byte first. Channel c lies on `smp_data[16c+15:16c]`, so channels 0x1234, 0x1245 and 0x0005 are sent as 34 12 45 12 05 00.
- R3: When a write frame completes, `rec_count` rises by exactly one and `byte_count` rises by exactly the record length (2 bytes per channel). Neither changes at any other time.
- R4: `full` is high exactly when `byte_count` plus the record length exceeds the memory size. While `full` is high, strobes start no frame and change no counter.
- R5: A strobe that arrives while a write frame is in progress is dropped and sets `overrun`, which stays high until reset.
- R6: An upload request accepted while idle with a nonzero byte count produces one frame: 0x03, 0x00, 0x00, then `byte_count` exchanges. Each returned byte appears in order on `up_data`, and `up_last` is high only with the final byte.
- R7: An upload request while `byte_count` is zero starts no frame. Strobes during an upload are dropped without changing the counters or `overrun`.
- R8: While `spi_valid` is high and `spi_ready` is low, `spi_valid` stays high and `spi_tx` stays unchanged. `spi_valid` is only high while `spi_cs_n` is low.
- R9: While `up_valid` is high and `up_ready` is low, `up_valid`, `up_data` and `up_last` stay unchanged.
- R10: After reset, both counters are zero, `full`, `overrun`, `busy`, `spi_valid` and `up_valid` are low, and `spi_cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_stb | input | 1 | One-cycle sample strobe |
| smp_data | input | 16*NCH | Channel values, channel c on bits 16c+15:16c |
| upl_req | input | 1 | One-cycle upload request |
| spi_cs_n | output | 1 | Memory chip select, active low |
| spi_valid | output | 1 | Byte offered to the shifter |
| spi_ready | input | 1 | Shifter takes the offered byte |
| spi_tx | output | 8 | Byte to shift out |
| spi_rx_valid | input | 1 | Returned byte available (one cycle) |
| spi_rx | input | 8 | Byte shifted in |
| up_valid | output | 1 | Upload byte valid |
| up_ready | input | 1 | Upload consumer ready |
| up_data | output | 8 | Upload byte |
| up_last | output | 1 | Final upload byte |
| rec_count | output | CNT_W | Records stored |
| byte_count | output | CNT_W | Bytes stored, next write address |
| full | output | 1 | Next record would not fit |
| overrun | output | 1 | Sticky dropped-sample flag |
| busy | output | 1 | Frame in progress |

## Verification
The assertions assume that the shifter returns exactly one `spi_rx_valid` pulse for each accepted byte, and never before the byte has been taken. They also assume that `spi_ready` and `spi_rx_valid` are never raised while no exchange is pending. The bench's memory responder is a per-cycle state machine that only raises `spi_ready` after seeing `spi_valid`. It only pulses `spi_rx_valid` after a handshake, with rotating stall and latency counts. Strobes and upload requests are single-cycle pulses driven on falling edges, so they never overlap a reset.

// File: rtl/rlog_pkg.sv
`timescale 1ns/1ps
package rlog_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int unsigned WR_HDR = 4;
  localparam int unsigned RD_HDR = 3;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_XFER,
    ST_WAIT,
    ST_OUT
  } seq_state_t;
endpackage

// File: rtl/rlog_serializer.sv
`timescale 1ns/1ps
module rlog_serializer #(
  parameter int unsigned NCH = 3,
  localparam int unsigned REC_BYTES = 2 * NCH,
  localparam int unsigned BI_W = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [16*NCH-1:0]     din,
  input  logic [BI_W-1:0]       sel,
  output logic [7:0]            dout
);
  logic [16*NCH-1:0] rec_q;
  logic [7:0]        bytes [REC_BYTES];

  always_ff @(posedge clk) begin
    if (!rst_n)    rec_q <= '0;
    else if (load) rec_q <= din;
  end

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    assign bytes[2*c]   = rec_q[16*c +: 8];
    assign bytes[2*c+1] = rec_q[16*c+8 +: 8];
  end

  always_comb begin
    dout = 8'h00;
    for (int k = 0; k < REC_BYTES; k++)
      if (sel == BI_W'(k)) dout = bytes[k];
  end
endmodule

// File: rtl/rlog_counters.sv
`timescale 1ns/1ps
module rlog_counters #(
  parameter int unsigned REC_BYTES = 6,
  parameter int unsigned MEM_BYTES = 32768,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  output logic [CNT_W-1:0] rec_count,
  output logic [CNT_W-1:0] byte_count,
  output logic             full
);
  localparam logic [CNT_W-1:0] STEP  = CNT_W'(REC_BYTES);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MEM_BYTES - REC_BYTES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rec_count  <= '0;
      byte_count <= '0;
    end else if (commit) begin
      rec_count  <= rec_count + 1'b1;
      byte_count <= byte_count + STEP;
    end
  end

  assign full = byte_count > LIMIT;
endmodule

// File: rtl/rlog_seq.sv
`timescale 1ns/1ps
module rlog_seq
  import rlog_pkg::*;
#(
  parameter int unsigned REC_BYTES = 6,
  parameter int unsigned CNT_W = 16,
  localparam int unsigned PW = CNT_W + 1,
  localparam int unsigned BI_W = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             smp_stb,
  input  logic             upl_req,
  input  logic             full,
  input  logic [CNT_W-1:0] byte_count,
  input  logic [7:0]       rec_byte,
  output logic [BI_W-1:0]  sel,
  output logic             load,
  output logic             commit,
  output logic             spi_cs_n,
  output logic             spi_valid,
  input  logic             spi_ready,
  output logic [7:0]       spi_tx,
  input  logic             spi_rx_valid,
  input  logic [7:0]       spi_rx,
  output logic             up_valid,
  input  logic             up_ready,
  output logic [7:0]       up_data,
  output logic             up_last,
  output logic             overrun,
  output logic             busy
);
  seq_state_t    state;
  logic          wr_mode;
  logic [PW-1:0] pos;
  logic [PW-1:0] last;
  logic [15:0]   addr16;
  logic          at_last;
  logic          start_up;

  assign addr16   = 16'(byte_count);
  assign at_last  = (pos == last);
  assign load     = (state == ST_IDLE) && smp_stb && !full;
  assign start_up = (state == ST_IDLE) && !load && upl_req && (byte_count != '0);
  assign commit   = (state == ST_WAIT) && spi_rx_valid && wr_mode && at_last;
  assign sel      = BI_W'(pos - PW'(WR_HDR));

  assign busy      = (state != ST_IDLE);
  assign spi_cs_n  = (state == ST_IDLE);
  assign spi_valid = (state == ST_XFER);
  assign up_valid  = (state == ST_OUT);
  assign up_last   = (state == ST_OUT) && at_last;

  always_comb begin
    if (wr_mode) begin
      case (pos)
        PW'(0):  spi_tx = OP_WREN;
        PW'(1):  spi_tx = OP_WRITE;
        PW'(2):  spi_tx = addr16[15:8];
        PW'(3):  spi_tx = addr16[7:0];
        default: spi_tx = rec_byte;
      endcase
    end else begin
      spi_tx = (pos == '0) ? OP_READ : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      wr_mode <= 1'b0;
      pos     <= '0;
      last    <= '0;
      up_data <= '0;
      overrun <= 1'b0;
    end else begin
      if (smp_stb && (state != ST_IDLE) && wr_mode) overrun <= 1'b1;
      case (state)
        ST_IDLE: begin
          if (load) begin
            wr_mode <= 1'b1;
            pos     <= '0;
            last    <= PW'(REC_BYTES + WR_HDR - 1);
            state   <= ST_XFER;
          end else if (start_up) begin
            wr_mode <= 1'b0;
            pos     <= '0;
            last    <= PW'(byte_count) + PW'(RD_HDR - 1);
            state   <= ST_XFER;
          end
        end
        ST_XFER: if (spi_ready) state <= ST_WAIT;
        ST_WAIT: begin
          if (spi_rx_valid) begin
            if (!wr_mode && (pos >= PW'(RD_HDR))) begin
              up_data <= spi_rx;
              state   <= ST_OUT;
            end else if (at_last) begin
              state <= ST_IDLE;
            end else begin
              pos   <= pos + 1'b1;
              state <= ST_XFER;
            end
          end
        end
        ST_OUT: begin
          if (up_ready) begin
            if (at_last) state <= ST_IDLE;
            else begin
              pos   <= pos + 1'b1;
              state <= ST_XFER;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rec_logger.sv
`timescale 1ns/1ps
module rec_logger #(
  parameter int unsigned NCH = 3,
  parameter int unsigned MEM_BYTES = 32768,
  localparam int unsigned REC_BYTES = 2 * NCH,
  localparam int unsigned CNT_W = $clog2(MEM_BYTES + 1),
  localparam int unsigned BI_W = (REC_BYTES > 1) ? $clog2(REC_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_stb,
  input  logic [16*NCH-1:0] smp_data,
  input  logic              upl_req,
  output logic              spi_cs_n,
  output logic              spi_valid,
  input  logic              spi_ready,
  output logic [7:0]        spi_tx,
  input  logic              spi_rx_valid,
  input  logic [7:0]        spi_rx,
  output logic              up_valid,
  input  logic              up_ready,
  output logic [7:0]        up_data,
  output logic              up_last,
  output logic [CNT_W-1:0]  rec_count,
  output logic [CNT_W-1:0]  byte_count,
  output logic              full,
  output logic              overrun,
  output logic              busy
);
  logic            load;
  logic            commit;
  logic [BI_W-1:0] sel;
  logic [7:0]      rec_byte;

  rlog_serializer #(.NCH(NCH)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .din(smp_data),
    .sel(sel), .dout(rec_byte)
  );

  rlog_counters #(.REC_BYTES(REC_BYTES), .MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .commit(commit),
    .rec_count(rec_count), .byte_count(byte_count), .full(full)
  );

  rlog_seq #(.REC_BYTES(REC_BYTES), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb), .upl_req(upl_req),
    .full(full), .byte_count(byte_count), .rec_byte(rec_byte), .sel(sel),
    .load(load), .commit(commit),
    .spi_cs_n(spi_cs_n), .spi_valid(spi_valid), .spi_ready(spi_ready),
    .spi_tx(spi_tx), .spi_rx_valid(spi_rx_valid), .spi_rx(spi_rx),
    .up_valid(up_valid), .up_ready(up_ready), .up_data(up_data),
    .up_last(up_last), .overrun(overrun), .busy(busy)
  );
endmodule

// File: rtl/rlog_chk.sv
`timescale 1ns/1ps
module rlog_chk #(
  parameter int unsigned REC_BYTES = 6,
  parameter int unsigned MEM_BYTES = 32768,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             spi_cs_n,
  input logic             spi_valid,
  input logic             spi_ready,
  input logic [7:0]       spi_tx,
  input logic             up_valid,
  input logic             up_ready,
  input logic [7:0]       up_data,
  input logic             up_last,
  input logic [CNT_W-1:0] rec_count,
  input logic [CNT_W-1:0] byte_count,
  input logic             full,
  input logic             overrun
);
  localparam logic [CNT_W-1:0] STEP = CNT_W'(REC_BYTES);
  localparam logic [CNT_W-1:0] MAXB = CNT_W'(MEM_BYTES);

  a_r8_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid && !spi_ready |=> spi_valid && $stable(spi_tx));

  a_r8_cs_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_valid |-> !spi_cs_n);

  a_r9_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid && !up_ready |=> up_valid && $stable(up_data) && $stable(up_last));

  a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_count) |-> (byte_count == $past(byte_count) + STEP)
                             && (rec_count == $past(rec_count) + 1'b1));

  a_r3_together: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(byte_count) |-> $stable(rec_count));

  a_r4_bound: assert property (@(posedge clk) disable iff (!rst_n)
    byte_count <= MAXB);

  a_r4_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    full |=> $stable(byte_count));

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);

  a_r7_upload_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> $stable(byte_count));
endmodule

bind rec_logger rlog_chk #(
  .REC_BYTES(REC_BYTES), .MEM_BYTES(MEM_BYTES), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_valid(spi_valid),
  .spi_ready(spi_ready), .spi_tx(spi_tx), .up_valid(up_valid),
  .up_ready(up_ready), .up_data(up_data), .up_last(up_last),
  .rec_count(rec_count), .byte_count(byte_count), .full(full),
  .overrun(overrun)
);

// File: tb/sim_rec_logger.sv
`timescale 1ns/1ps
module sim_rec_logger;
  localparam int NCH = 3;
  localparam int MEMB = 64;
  localparam int RB = 2 * NCH;
  localparam int CW = $clog2(MEMB + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_stb = 1'b0;
  logic [16*NCH-1:0] smp_data = '0;
  logic upl_req = 1'b0;
  logic spi_cs_n, spi_valid, spi_ready = 1'b0;
  logic [7:0] spi_tx, spi_rx = 8'h00;
  logic spi_rx_valid = 1'b0;
  logic up_valid, up_ready = 1'b0, up_last;
  logic [7:0] up_data;
  logic [CW-1:0] rec_count, byte_count;
  logic full, overrun, busy;

  always #10 clk = ~clk;

  rec_logger #(.NCH(NCH), .MEM_BYTES(MEMB)) u0 (.*);

  int errors = 0, checks = 0;
  bit done = 0;

  // memory responder state
  logic [7:0] fmem [MEMB];
  logic [7:0] exp_mem [MEMB];
  int sl_st = 0, sl_cnt = 0, xcount = 0, phase = 0, frames = 0;
  logic [7:0] sl_b, sl_rx, op;
  logic wel;
  logic [15:0] addr;
  logic [7:0] f_first, f_op;
  logic [15:0] f_addr;
  logic f_wel;

  // upload sink
  logic [7:0] got [MEMB];
  int nup = 0, nlast = 0, last_at = -1, ucnt = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < MEMB; i++) fmem[i] = 8'hEE;
    forever begin
      @(negedge clk);
      spi_ready = 1'b0;
      spi_rx_valid = 1'b0;
      if (sl_st == 0 && spi_cs_n) begin phase = 0; wel = 1'b0; end
      case (sl_st)
        0: if (spi_valid) begin
             sl_b = spi_tx; sl_cnt = xcount % 3; xcount++; sl_st = 1;
           end
        1: if (sl_cnt == 0) begin
             spi_ready = 1'b1;
             sl_rx = 8'h5A;
             case (phase)
               0: begin
                    if (sl_b == 8'h06) begin wel = 1'b1; f_first = sl_b; frames++; end
                    else begin
                      if (!wel) begin f_first = sl_b; frames++; end
                      op = sl_b; f_op = sl_b; f_wel = wel; phase = 1;
                    end
                  end
               1: begin addr[15:8] = sl_b; phase = 2; end
               2: begin addr[7:0] = sl_b; f_addr = addr; phase = 3; end
               default: begin
                 if (op == 8'h02 && wel) fmem[addr % MEMB] = sl_b;
                 if (op == 8'h03) sl_rx = fmem[addr % MEMB];
                 addr = addr + 16'd1;
               end
             endcase
             sl_cnt = xcount % 2; sl_st = 2;
           end else sl_cnt--;
        2: if (sl_cnt == 0) begin
             spi_rx = sl_rx; spi_rx_valid = 1'b1; sl_st = 0;
           end else sl_cnt--;
        default: sl_st = 0;
      endcase
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      up_ready = (ucnt % 3) != 1;
      ucnt++;
      if (up_valid && up_ready) begin
        if (nup < MEMB) got[nup] = up_data;
        if (up_last) begin nlast++; last_at = nup; end
        nup++;
      end
    end
  end

  function automatic logic [15:0] chv(input int r, input int c);
    if (r == 0) return (c == 0) ? 16'h1234 : (c == 1) ? 16'h1245 : 16'h0005;
    return 16'((r * 16'h0731) ^ (c * 16'h9E0F) ^ 16'h8001);
  endfunction

  function automatic logic [16*NCH-1:0] recv(input int r);
    logic [16*NCH-1:0] v;
    for (int c = 0; c < NCH; c++) v[16*c +: 16] = chv(r, c);
    return v;
  endfunction

  task automatic strobe(input int r);
    @(negedge clk); smp_data = recv(r); smp_stb = 1'b1;
    @(negedge clk); smp_stb = 1'b0;
  endtask

  task automatic upload();
    nup = 0; nlast = 0; last_at = -1;
    @(negedge clk); upl_req = 1'b1;
    @(negedge clk); upl_req = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // expected bytes of record r go to exp_mem at slot s (R2: low byte first, channel 0 first)
  task automatic expect_rec(input int r, input int s);
    for (int c = 0; c < NCH; c++) begin
      exp_mem[s*RB + 2*c]     = chv(r, c)[7:0];
      exp_mem[s*RB + 2*c + 1] = chv(r, c)[15:8];
    end
  endtask

  task automatic check_rec(input int s, input string tag);
    logic [8*RB-1:0] a, e;
    for (int k = 0; k < RB; k++) begin
      a[8*k +: 8] = fmem[s*RB + k];
      e[8*k +: 8] = exp_mem[s*RB + k];
    end
    chk(a == e, tag, a, e);
  endtask

  task automatic check_upload(input int n, input string tag);
    chk(nup == n, {tag, " R6 byte count"}, nup, n);
    for (int k = 0; k < n; k++)
      chk(got[k] == exp_mem[k], {tag, " R6 data"}, got[k], exp_mem[k]);
    chk(nlast == 1 && last_at == n - 1, {tag, " R6 last position"}, last_at, n - 1);
    chk(f_first == 8'h03 && f_addr == 16'h0000, {tag, " R6 read header"}, {f_first, f_addr}, 24'h030000);
  endtask

  initial begin
    int slot, fr;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(rec_count == 0 && byte_count == 0, "R10 counters", {rec_count, byte_count}, 0);
    chk(!full && !overrun && !busy, "R10 flags", {full, overrun, busy}, 0);
    chk(spi_cs_n && !spi_valid && !up_valid, "R10 bus idle", {spi_cs_n, spi_valid, up_valid}, 3'b100);

    // R7 upload with nothing stored
    upload();
    repeat (12) @(negedge clk);
    chk(frames == 0 && nup == 0 && !busy, "R7 empty upload", frames, 0);

    // R1 R2 R3 first record (documented example)
    expect_rec(0, 0);
    strobe(0); wait_idle();
    chk(frames == 1, "R1 one frame", frames, 1);
    chk(f_first == 8'h06 && f_op == 8'h02 && f_wel, "R1 opcodes", {f_first, f_op}, 16'h0602);
    chk(f_addr == 16'h0000, "R1 address", f_addr, 0);
    check_rec(0, "R2 example bytes 34 12 45 12 05 00");
    chk(rec_count == 1 && byte_count == RB, "R3 counters", {rec_count, byte_count}, {7'd1, 7'(RB)});

    expect_rec(1, 1);
    strobe(1); wait_idle();
    chk(f_addr == 16'(RB), "R1 second address", f_addr, RB);
    check_rec(1, "R2 record 1");

    // R6 mid upload, R7 strobe during upload dropped
    upload();
    repeat (8) @(negedge clk);
    chk(busy, "R7 upload in progress", busy, 1);
    strobe(2);
    wait_idle();
    check_upload(2 * RB, "early");
    chk(rec_count == 2 && byte_count == 2 * RB, "R7 counters unchanged", byte_count, 2 * RB);
    chk(!overrun, "R7 no overrun from upload", overrun, 0);

    // R5 overrun: second strobe during a write frame
    expect_rec(3, 2);
    fr = frames;
    strobe(3);
    @(negedge clk);
    strobe(4);
    wait_idle();
    chk(overrun, "R5 overrun set", overrun, 1);
    chk(frames == fr + 1 && byte_count == 3 * RB, "R5 sample dropped", byte_count, 3 * RB);
    check_rec(2, "R2 record after overrun");

    // R4 fill to capacity
    slot = 3;
    for (int r = 5; slot < MEMB / RB; r++) begin
      chk(!full, "R4 not full before fit", full, 0);
      expect_rec(r, slot);
      strobe(r); wait_idle();
      chk(byte_count == CW'((slot + 1) * RB), "R3 running count", byte_count, (slot + 1) * RB);
      chk(f_addr == 16'(slot * RB), "R1 frame address", f_addr, slot * RB);
      slot++;
    end
    chk(full, "R4 full at capacity", full, 1);
    fr = frames;
    strobe(40); wait_idle();
    chk(frames == fr && rec_count == CW'(slot), "R4 strobe ignored", rec_count, slot);
    chk(overrun, "R5 overrun still set", overrun, 1);
    for (int s = 0; s < slot; s++) check_rec(s, "R2 stored record");

    // R6 full upload
    upload();
    wait_idle();
    check_upload(slot * RB, "full");
    chk(byte_count == CW'(slot * RB), "R7 counts after upload", byte_count, slot * RB);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule